// File: doc/BRIEF.md
# BCD Real-Time Calendar Clock

This block keeps calendar time in packed-BCD byte registers and is advanced by a single-cycle 100 Hz tick pulse. It counts hundredths of a second, seconds, minutes, hours, day of the week, date, month and year. It handles short months and leap-year Februaries. Hours run in either a 24-hour format or a 12-hour format with an AM/PM flag. A byte-wide register port with a 6-bit address reads and writes every field. Each time the hundredths count wraps from 99 to 00 the block emits a one-cycle strobe, which alarm logic placed next to it can use.

The block holds two copies of the time. The working counters advance on every tick while the oscillator is enabled. The host-visible copy follows them as long as the transfer-enable bit is 1. When software clears that bit, the host copy freezes, so software can read or write all the fields as one coherent set while the working counters keep running. Fields written during the freeze are merged into the working counters at the moment transfer-enable is set again. Fields not written pick up the time that went on accumulating.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read as follows: hundredths, seconds, minutes, hours and year are 00. Day and date are 01. The month register reads 81h, meaning the oscillator is stopped and the month is 01. The command register at 0Bh reads 80h, meaning transfer-enable is 1.
- R2: Bit 7 of the month register (09h) stops the oscillator when it is 1. While it is 1, ticks change no time field. While it is 0, each tick advances the hundredths register (00h) by one in BCD, so 09 is followed by 10.
- R3: The cascade into the higher fields happens only when the hundredths register wraps from 99 to 00. Seconds (01h) and minutes (02h) wrap at 59. Day of week (06h) wraps from 7 to 1. Month (09h, bits 4:0) wraps from 12 to 01. Year (0Ah) wraps from 99 to 00.
- R4: The output `rollover_o` is high for exactly the one cycle after a clock edge at which an enabled tick wrapped the working hundredths count from 99 to 00. At all other times it is low.
- R5: The date (08h) wraps to 01 after day 30 in months 04, 06, 09 and 11. In February of a non-leap year it wraps after day 28. In every other month it wraps after day 31. Each such wrap advances the month.
- R6: A year value divisible by 4 (00, 12, 24 and so on) lets February reach day 29. Year 10 does not.
- R7: In 24-hour mode (hours register bit 6 = 0), bits 5:4 hold the tens of hours. The count runs 00 to 23, and a wrap from 23 to 00 advances the day.
- R8: In 12-hour mode (hours register bit 6 = 1), bit 5 is PM and bits 4:0 hold 01 to 12. The sequence goes 11 to 12 with the PM bit toggling, then 12 to 01. The day advances only at 11 PM to 12 AM.
- R9: Unused bits read 0, whatever value was written. These are bit 7 of seconds, minutes and hours, bits 7:3 of day, bits 7:6 of date, and bit 5 of month. Bits 7 and 6 of month read back as written.
- R10: Writing 0 to bit 7 of 0Bh freezes the host copy while the working counters continue. Writing 1 to that bit again shows the time that elapsed in the meantime.
- R11: With transfer-enable at 1, a write to a time field takes effect at once. With it at 0, the write shows in the host copy and reaches the working counters when transfer-enable is set again.
- R12: Addresses outside the time fields and 0Bh read 0. In 0Bh only bit 7 is stored; the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle 100 Hz time-base pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational from the host copy |
| rollover_o | output | 1 | Hundredths 99-to-00 strobe |

## Verification
The bench uses the defaults ADDR_W = 6 and OSC_OFF_AT_RESET = 1. The block therefore comes out of reset with the oscillator stopped, which tests the stopped path before software starts the clock. Because the host port can load every field, the bench jumps straight to one tick before each rollover of interest. That puts the full year cascade, every month length, the leap and non-leap Februaries, and both hour formats within a few cycles each. The freeze and resume sequence is timed so that the hidden working counters advance a known number of hundredths while the host copy stands still.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NUM_FIELDS = 8;
  localparam logic [5:0] ADR_CMD = 6'h0B;
  localparam logic [5:0] ADR_MON = 6'h09;

  localparam int F_HUND = 0;
  localparam int F_SEC  = 1;
  localparam int F_MIN  = 2;
  localparam int F_HOUR = 3;
  localparam int F_DOW  = 4;
  localparam int F_DATE = 5;
  localparam int F_MON  = 6;
  localparam int F_YEAR = 7;

  typedef struct packed {
    logic [7:0] hund;
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  localparam rtc_time_t TIME_RESET = '{hund: 8'h00, sec: 8'h00, min: 8'h00,
                                      hour: 8'h00, dow: 3'd1, date: 6'h01,
                                      mon: 5'h01, year: 8'h00};

  function automatic logic [5:0] field_addr(input int idx);
    case (idx)
      F_HUND:  return 6'h00;
      F_SEC:   return 6'h01;
      F_MIN:   return 6'h02;
      F_HOUR:  return 6'h04;
      F_DOW:   return 6'h06;
      F_DATE:  return 6'h08;
      F_MON:   return 6'h09;
      default: return 6'h0A;
    endcase
  endfunction

  function automatic logic [7:0] get_field(input rtc_time_t t, input int idx);
    case (idx)
      F_HUND:  return t.hund;
      F_SEC:   return t.sec;
      F_MIN:   return t.min;
      F_HOUR:  return t.hour;
      F_DOW:   return {5'b0, t.dow};
      F_DATE:  return {2'b0, t.date};
      F_MON:   return {3'b0, t.mon};
      default: return t.year;
    endcase
  endfunction

  function automatic rtc_time_t put_field(input rtc_time_t t, input int idx,
                                          input logic [7:0] v);
    rtc_time_t r;
    r = t;
    case (idx)
      F_HUND:  r.hund = v;
      F_SEC:   r.sec  = {1'b0, v[6:0]};
      F_MIN:   r.min  = {1'b0, v[6:0]};
      F_HOUR:  r.hour = {1'b0, v[6:0]};
      F_DOW:   r.dow  = v[2:0];
      F_DATE:  r.date = v[5:0];
      F_MON:   r.mon  = v[4:0];
      default: r.year = v;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [3:0] lo, hi;
    if (v[3:0] >= 4'd9) begin
      lo = 4'd0;
      hi = (v[7:4] >= 4'd9) ? 4'd0 : v[7:4] + 4'd1;
    end else begin
      lo = v[3:0] + 4'd1;
      hi = v[7:4];
    end
    return {hi, lo};
  endfunction

  // Tens digit contributes 10*t, which is 2*t modulo 4.
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_reset_sync.sv
module rtc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_time_step.sv
module rtc_time_step
  import rtc_pkg::*;
(
  input  rtc_time_t cur_i,
  input  logic      advance_i,
  output rtc_time_t nxt_o,
  output logic      wrap_o
);
  logic       c_min, c_hr, c_day, c_mon, c_yr;
  logic [7:0] h8;

  always_comb begin
    nxt_o  = cur_i;
    wrap_o = advance_i && (cur_i.hund == 8'h99);
    c_min  = 1'b0;
    c_hr   = 1'b0;
    c_day  = 1'b0;
    c_mon  = 1'b0;
    c_yr   = 1'b0;
    h8     = 8'h00;

    if (advance_i) nxt_o.hund = bcd_inc(cur_i.hund);

    if (wrap_o) begin
      c_min     = (cur_i.sec == 8'h59);
      nxt_o.sec = c_min ? 8'h00 : bcd_inc(cur_i.sec);
    end

    if (c_min) begin
      c_hr      = (cur_i.min == 8'h59);
      nxt_o.min = c_hr ? 8'h00 : bcd_inc(cur_i.min);
    end

    if (c_hr) begin
      if (cur_i.hour[6]) begin
        // 12-hour: bit 5 PM, bits 4:0 hold 01..12
        h8 = bcd_inc({3'b0, cur_i.hour[4:0]});
        if (cur_i.hour[4:0] == 5'h12) begin
          nxt_o.hour = {2'b01, cur_i.hour[5], 5'h01};
        end else if (cur_i.hour[4:0] == 5'h11) begin
          nxt_o.hour = {2'b01, ~cur_i.hour[5], 5'h12};
          c_day      = cur_i.hour[5];
        end else begin
          nxt_o.hour = {2'b01, cur_i.hour[5], h8[4:0]};
        end
      end else begin
        h8 = bcd_inc({2'b0, cur_i.hour[5:0]});
        if (cur_i.hour[5:0] == 6'h23) begin
          nxt_o.hour = 8'h00;
          c_day      = 1'b1;
        end else begin
          nxt_o.hour = {2'b00, h8[5:0]};
        end
      end
    end

    if (c_day) begin
      nxt_o.dow = (cur_i.dow >= 3'd7) ? 3'd1 : cur_i.dow + 3'd1;
      c_mon     = (cur_i.date == last_day(cur_i.mon, cur_i.year));
      h8        = bcd_inc({2'b0, cur_i.date});
      nxt_o.date = c_mon ? 6'h01 : h8[5:0];
    end

    if (c_mon) begin
      c_yr      = (cur_i.mon == 5'h12);
      h8        = bcd_inc({3'b0, cur_i.mon});
      nxt_o.mon = c_yr ? 5'h01 : h8[4:0];
    end

    if (c_yr) nxt_o.year = bcd_inc(cur_i.year);
  end
endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
  import rtc_pkg::*;
#(
  parameter int   ADDR_W           = 6,
  parameter logic OSC_OFF_AT_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  rtc_time_t         int_adv_i,
  output rtc_time_t         int_d_o,
  output rtc_time_t         host_q_o,
  output logic              te_o,
  output logic              osc_off_o,
  output logic [7:0]        rdata_o
);
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(ADR_CMD);
  localparam logic [ADDR_W-1:0] MON_A = ADDR_W'(ADR_MON);

  rtc_time_t             host_q, host_d, host_new, int_d;
  logic [NUM_FIELDS-1:0] wr_hit, take, dirty_q, dirty_d;
  logic                  te_q, te_d, osc_off_q, osc_off_d, ubit_q, ubit_d;
  logic                  cmd_hit, resume, host_en;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    assign wr_hit[i]  = wr_i && (addr_i == ADDR_W'(field_addr(i)));
    assign take[i]    = (wr_hit[i] && te_q) || (resume && dirty_q[i]);
    assign dirty_d[i] = resume ? 1'b0 : ((wr_hit[i] && !te_q) ? 1'b1 : dirty_q[i]);
  end

  assign cmd_hit   = wr_i && (addr_i == CMD_A);
  assign resume    = cmd_hit && wdata_i[7] && !te_q;
  assign te_d      = cmd_hit ? wdata_i[7] : te_q;
  assign osc_off_d = wr_hit[F_MON] ? wdata_i[7] : osc_off_q;
  assign ubit_d    = wr_hit[F_MON] ? wdata_i[6] : ubit_q;
  assign host_en   = te_q || resume || (|wr_hit);

  always_comb begin
    host_new = host_q;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (wr_hit[i]) host_new = put_field(host_new, i, wdata_i);
  end

  always_comb begin
    int_d = int_adv_i;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (take[i]) int_d = put_field(int_d, i, get_field(host_new, i));
  end

  assign host_d = (te_q || resume) ? int_d : host_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q    <= TIME_RESET;
      dirty_q   <= '0;
      te_q      <= 1'b1;
      osc_off_q <= OSC_OFF_AT_RESET;
      ubit_q    <= 1'b0;
    end else begin
      if (host_en) host_q <= host_d;
      dirty_q   <= dirty_d;
      te_q      <= te_d;
      osc_off_q <= osc_off_d;
      ubit_q    <= ubit_d;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (addr_i == ADDR_W'(field_addr(i))) rdata_o = get_field(host_q, i);
    if (addr_i == MON_A) rdata_o[7:6] = {osc_off_q, ubit_q};
    if (addr_i == CMD_A) rdata_o = {te_q, 7'b0};
  end

  assign int_d_o   = int_d;
  assign host_q_o  = host_q;
  assign te_o      = te_q;
  assign osc_off_o = osc_off_q;
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int   ADDR_W           = 6,
  parameter logic OSC_OFF_AT_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              rollover_o
);
  logic      rst_sync_n, te_q, osc_off_q, advance, wrap, roll_q;
  rtc_time_t int_q, int_adv, int_d, host_q;

  rtc_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign advance = tick_i && !osc_off_q;

  rtc_time_step u_step (
    .cur_i(int_q), .advance_i(advance), .nxt_o(int_adv), .wrap_o(wrap)
  );

  rtc_host_regs #(.ADDR_W(ADDR_W), .OSC_OFF_AT_RESET(OSC_OFF_AT_RESET)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .int_adv_i(int_adv), .int_d_o(int_d),
    .host_q_o(host_q), .te_o(te_q), .osc_off_o(osc_off_q), .rdata_o(reg_rdata_o)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      int_q  <= TIME_RESET;
      roll_q <= 1'b0;
    end else begin
      int_q  <= int_d;
      roll_q <= wrap;
    end
  end

  assign rollover_o = roll_q;
endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_sync_n,
  input logic              tick_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [7:0]        reg_rdata_o,
  input logic              rollover_o,
  input rtc_time_t         int_q,
  input rtc_time_t         host_q,
  input logic              te_q,
  input logic              osc_off_q
);
  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (osc_off_q && !reg_wr_i) |=> $stable(int_q));

  a_r4_wrap_strobe: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (tick_i && !osc_off_q && int_q.hund == 8'h99 && !reg_wr_i) |=> (rollover_o && int_q.hund == 8'h00));

  a_r10_frozen_copy: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (!te_q && !reg_wr_i) |=> $stable(host_q));

  a_r10_mirror: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    te_q |-> (host_q == int_q));

  a_r9_dow_unused: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (reg_addr_i == ADDR_W'(6'h06)) |-> (reg_rdata_o[7:3] == 5'b0));

  a_r12_hole_zero: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (reg_addr_i == ADDR_W'(6'h03)) |-> (reg_rdata_o == 8'h00));
endmodule

bind bcd_rtc_core rtc_core_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n), .tick_i(tick_i),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .rollover_o(rollover_o), .int_q(int_q), .host_q(host_q), .te_q(te_q),
  .osc_off_q(osc_off_q)
);

// File: tb/sim_bcd_rtc_core.sv
module sim_bcd_rtc_core;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit         is_strobe;
    logic [7:0] exp;
    logic [5:0] addr;
    string      tag;
  } item_t;

  logic       clk, rst_n, tick, wr, roll;
  logic [5:0] addr;
  logic [7:0] wdata, rdata;
  item_t      sb_q[$];
  int         n_vec, n_bad;
  bit         done;

  bcd_rtc_core u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rollover_o(roll)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: pops one expectation per clock, just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = sb_q.pop_front();
        act = it.is_strobe ? {7'b0, roll} : rdata;
        n_vec++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s addr=%02h actual=%02h expected=%02h", it.tag, it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic chk(input logic [5:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.is_strobe = 1'b0; it.exp = e; it.addr = a; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse_strobe(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    tick = 1'b1;
    it.is_strobe = 1'b1; it.exp = {7'b0, e}; it.addr = 6'h00; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    tick = 1'b0;
  endtask

  // Load one hundredth before a full minute/hour rollover, then tick once.
  task automatic edge_of(input logic [7:0] hr, input logic [7:0] dt,
                         input logic [7:0] mo, input logic [7:0] yr);
    wr_reg(6'h00, 8'h99); wr_reg(6'h01, 8'h59); wr_reg(6'h02, 8'h59);
    wr_reg(6'h04, hr); wr_reg(6'h08, dt); wr_reg(6'h09, mo); wr_reg(6'h0A, yr);
    pulse_strobe(1'b1, "R4 strobe on wrap");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; tick = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(6'h00, 8'h00, "R1 hundredths");
    chk(6'h04, 8'h00, "R1 hours");
    chk(6'h06, 8'h01, "R1 day");
    chk(6'h08, 8'h01, "R1 date");
    chk(6'h09, 8'h81, "R1 month with osc stopped");
    chk(6'h0A, 8'h00, "R1 year");
    chk(6'h0B, 8'h80, "R1 command");

    pulse(3);
    chk(6'h00, 8'h00, "R2 stopped osc holds");
    wr_reg(6'h09, 8'h01);
    pulse(3);
    chk(6'h00, 8'h03, "R2 counting");
    wr_reg(6'h00, 8'h09);
    pulse(1);
    chk(6'h00, 8'h10, "R2 BCD carry 09 to 10");

    wr_reg(6'h01, 8'hFF); chk(6'h01, 8'h7F, "R9 seconds bit7");
    wr_reg(6'h06, 8'hFF); chk(6'h06, 8'h07, "R9 day bits");
    wr_reg(6'h08, 8'hFF); chk(6'h08, 8'h3F, "R9 date bits");
    wr_reg(6'h09, 8'h72); chk(6'h09, 8'h52, "R9 month bit5 drops, bit6 kept");

    // R3: full cascade 23:59:59.99, Sat 31 Dec 99
    wr_reg(6'h00, 8'h98); wr_reg(6'h01, 8'h59); wr_reg(6'h02, 8'h59);
    wr_reg(6'h04, 8'h23); wr_reg(6'h06, 8'h07); wr_reg(6'h08, 8'h31);
    wr_reg(6'h09, 8'h12); wr_reg(6'h0A, 8'h99);
    pulse_strobe(1'b0, "R4 no strobe 98 to 99");
    chk(6'h00, 8'h99, "R3 no cascade before wrap");
    chk(6'h01, 8'h59, "R3 seconds held before wrap");
    pulse_strobe(1'b1, "R4 strobe 99 to 00");
    chk(6'h00, 8'h00, "R3 hundredths");
    chk(6'h01, 8'h00, "R3 seconds");
    chk(6'h02, 8'h00, "R3 minutes");
    chk(6'h04, 8'h00, "R7 hours 23 to 00");
    chk(6'h06, 8'h01, "R3 day 7 to 1");
    chk(6'h08, 8'h01, "R3 date");
    chk(6'h09, 8'h01, "R3 month 12 to 01");
    chk(6'h0A, 8'h00, "R3 year 99 to 00");

    edge_of(8'h23, 8'h28, 8'h02, 8'h23);
    chk(6'h08, 8'h01, "R5 Feb 28 non-leap date"); chk(6'h09, 8'h03, "R5 Feb to Mar");
    edge_of(8'h23, 8'h30, 8'h04, 8'h05);
    chk(6'h08, 8'h01, "R5 Apr 30 date"); chk(6'h09, 8'h05, "R5 Apr to May");
    edge_of(8'h23, 8'h30, 8'h05, 8'h05);
    chk(6'h08, 8'h31, "R5 May 30 to 31");
    edge_of(8'h23, 8'h30, 8'h09, 8'h05);
    chk(6'h09, 8'h10, "R5 Sep to Oct BCD");

    edge_of(8'h23, 8'h28, 8'h02, 8'h24);
    chk(6'h08, 8'h29, "R6 leap 24 Feb 29");
    edge_of(8'h23, 8'h29, 8'h02, 8'h24);
    chk(6'h08, 8'h01, "R6 leap Feb 29 wrap"); chk(6'h09, 8'h03, "R6 leap to Mar");
    edge_of(8'h23, 8'h28, 8'h02, 8'h12);
    chk(6'h08, 8'h29, "R6 leap 12");
    edge_of(8'h23, 8'h28, 8'h02, 8'h00);
    chk(6'h08, 8'h29, "R6 leap 00");
    edge_of(8'h23, 8'h28, 8'h02, 8'h10);
    chk(6'h08, 8'h01, "R6 year 10 not leap");

    edge_of(8'h19, 8'h10, 8'h06, 8'h05);
    chk(6'h04, 8'h20, "R7 hours 19 to 20"); chk(6'h08, 8'h10, "R7 no day change");

    edge_of(8'h51, 8'h10, 8'h06, 8'h05);
    chk(6'h04, 8'h72, "R8 11 AM to 12 PM"); chk(6'h08, 8'h10, "R8 no day at noon");
    edge_of(8'h72, 8'h10, 8'h06, 8'h05);
    chk(6'h04, 8'h61, "R8 12 PM to 01 PM");
    edge_of(8'h71, 8'h10, 8'h06, 8'h05);
    chk(6'h04, 8'h52, "R8 11 PM to 12 AM"); chk(6'h08, 8'h11, "R8 day at midnight");
    edge_of(8'h49, 8'h11, 8'h06, 8'h05);
    chk(6'h04, 8'h50, "R8 09 AM to 10 AM");

    wr_reg(6'h00, 8'h10);
    chk(6'h00, 8'h10, "R11 immediate write");
    wr_reg(6'h0B, 8'h00);
    chk(6'h0B, 8'h00, "R10 TE cleared");
    pulse(5);
    chk(6'h00, 8'h10, "R10 frozen copy");
    wr_reg(6'h01, 8'h30);
    chk(6'h01, 8'h30, "R11 write shows while frozen");
    wr_reg(6'h0B, 8'h80);
    chk(6'h00, 8'h15, "R10 elapsed time kept");
    chk(6'h01, 8'h30, "R11 frozen write loaded");
    pulse(1);
    chk(6'h00, 8'h16, "R10 counting resumed");
    chk(6'h01, 8'h30, "R11 loaded seconds persist");

    chk(6'h03, 8'h00, "R12 hole 03");
    chk(6'h3F, 8'h00, "R12 hole 3F");
    wr_reg(6'h07, 8'hFF); chk(6'h07, 8'h00, "R12 write to hole ignored");
    wr_reg(6'h0B, 8'hFF); chk(6'h0B, 8'h80, "R12 command only bit7");

    wr_reg(6'h09, 8'h86);
    pulse(2);
    chk(6'h00, 8'h16, "R2 osc stop by month bit7");
    chk(6'h09, 8'h86, "R9 month control bits read back");

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule